// File: doc/BRIEF.md
# Four-Channel DMA Register File

This block is the host side of a four-channel DMA controller. A host reaches it through one 8-bit data path and a 4-bit offset. Behind that path it keeps, for each channel, a 16-bit start address, a 16-bit transfer count and a 6-bit mode. It also keeps a four-bit channel mask, a command byte, software request bits and terminal-count status. All of these are presented in parallel to a transfer engine.

Each 16-bit quantity is reached as two consecutive byte accesses at one offset. A shared byte-pointer flip-flop decides whether an access hits the low byte or the high byte. The pointer returns to the low byte only through an explicit clear command, a master clear or reset.

The transfer engine can overwrite the current address and count of a channel as it progresses. The host sees those current values on readback, and the programmed base copies are kept. The engine reports the end of a transfer with a terminal-count pulse. The pulse is held in the status byte until the host reads it.

Top module: `dmac_regfile`

## Requirements
- R1: After reset the mask is 4'b1111 and the command byte, software requests, terminal-count bits, byte pointer, modes, addresses and counts are all zero.
- R2: For channel n, offset 2n holds the address and offset 2n+1 holds the count. A write stores the low byte when the pointer is low and the high byte when it is high, and updates both the base and the current copy.
- R3: Every read or write at offsets 0x0 to 0x7 toggles one pointer shared by all channels and both register kinds. A read at those offsets returns the selected byte of the current copy. A read and a write are never issued in the same cycle.
- R4: A write of any data to offset 0xC returns the pointer to the low byte.
- R5: A write to offset 0xA selects a channel with data bits 1:0 and sets that channel's mask bit to data bit 2. A mask bit of 1 disables the channel.
- R6: A write to offset 0xE clears all mask bits. A write to offset 0xF loads mask bit n from data bit n for n from 0 to 3.
- R7: A write to offset 0xB selects a channel with data bits 1:0 and stores data bits 7:2 as that channel's mode. For example 0x44 stores 6'h11, 0x48 stores 6'h12, 0x54 (0x44 with autoinit) stores 6'h15 and 0xC0 stores 6'h30.
- R8: A write to offset 0x8 stores the command byte. A write to offset 0x9 selects a channel with data bits 1:0 and sets that channel's software request bit to data bit 2.
- R9: A read at offset 0x8 returns bits 7:4 = software request OR hardware request, and bits 3:0 = latched terminal count, where bit n is channel n. The read clears bits 3:0. A terminal-count pulse in the same cycle as the read is kept.
- R10: A write to offset 0xD sets all mask bits and clears the pointer, the command byte, the software requests and the terminal-count bits. Addresses, counts and modes are kept.
- R11: An engine update of channel n loads that channel's current address and current count and leaves its base copies unchanged.
- R12: Reads at offsets 0x9 to 0xF return 0x00 and change neither the pointer nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_wr | input | 1 | Host write strobe |
| io_rd | input | 1 | Host read strobe |
| io_addr | input | 4 | Register offset |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data (combinational) |
| tc_in | input | 4 | Terminal-count pulses from the engine, one per channel |
| dreq_in | input | 4 | Hardware request levels, one per channel |
| eng_wr | input | 4 | Engine update strobes, one per channel |
| eng_addr | input | 16 | Engine current address value |
| eng_cnt | input | 16 | Engine current count value |
| base_addr | output | 64 | Base addresses, channel n in bits 16n+15:16n |
| cur_addr | output | 64 | Current addresses, same packing |
| base_cnt | output | 64 | Base counts, same packing |
| cur_cnt | output | 64 | Current counts, same packing |
| ch_mode | output | 24 | Modes, channel n in bits 6n+5:6n |
| ch_mask | output | 4 | Channel mask bits |
| cmd | output | 8 | Command byte |
| sw_req | output | 4 | Software request bits |

## Verification
The assertions assume that the host never raises its read and write strobes in the same cycle, because the pointer and status side effects are defined for one access at a time. The directed tasks issue every host access as a separate single-cycle strobe and drop it before the next one. Engine pulses and hardware request levels change only on the falling edge and never overlap a master clear, so each latched or cleared bit has exactly one source in any cycle.

// File: rtl/dmac_regfile.sv
module dmac_regfile #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int MW  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [3:0]       io_addr,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  input  logic [NCH-1:0]   tc_in,
  input  logic [NCH-1:0]   dreq_in,
  input  logic [NCH-1:0]   eng_wr,
  input  logic [AW-1:0]    eng_addr,
  input  logic [AW-1:0]    eng_cnt,
  output logic [NCH*AW-1:0] base_addr,
  output logic [NCH*AW-1:0] cur_addr,
  output logic [NCH*AW-1:0] base_cnt,
  output logic [NCH*AW-1:0] cur_cnt,
  output logic [NCH*MW-1:0] ch_mode,
  output logic [NCH-1:0]   ch_mask,
  output logic [7:0]       cmd,
  output logic [NCH-1:0]   sw_req
);
  localparam logic [3:0] OFS_CMD  = 4'h8;
  localparam logic [3:0] OFS_REQ  = 4'h9;
  localparam logic [3:0] OFS_MSK1 = 4'hA;
  localparam logic [3:0] OFS_MODE = 4'hB;
  localparam logic [3:0] OFS_PTR  = 4'hC;
  localparam logic [3:0] OFS_MCLR = 4'hD;
  localparam logic [3:0] OFS_MCLA = 4'hE;
  localparam logic [3:0] OFS_MALL = 4'hF;

  logic           ptr_hi;
  logic [NCH-1:0] tc_q;
  logic [AW-1:0]  word;

  wire       data_ofs = ~io_addr[3];
  wire       data_acc = (io_wr | io_rd) & data_ofs;
  wire [1:0] sel_ch   = io_addr[2:1];
  wire [5:0] sel_base = {sel_ch, 4'b0000};
  wire       st_read  = io_rd && io_addr == OFS_CMD;
  wire       mclr     = io_wr && io_addr == OFS_MCLR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_hi  <= 1'b0;
      tc_q    <= '0;
      ch_mask <= '1;
      cmd     <= '0;
      sw_req  <= '0;
    end else begin
      if (data_acc) ptr_hi <= ~ptr_hi;
      tc_q <= (st_read ? '0 : tc_q) | tc_in;
      if (io_wr) begin
        case (io_addr)
          OFS_CMD:  cmd <= io_wdata;
          OFS_REQ:  sw_req[io_wdata[1:0]] <= io_wdata[2];
          OFS_MSK1: ch_mask[io_wdata[1:0]] <= io_wdata[2];
          OFS_PTR:  ptr_hi <= 1'b0;
          OFS_MCLR: begin
            ch_mask <= '1;
            ptr_hi  <= 1'b0;
            cmd     <= '0;
            tc_q    <= '0;
            sw_req  <= '0;
          end
          OFS_MCLA: ch_mask <= '0;
          OFS_MALL: ch_mask <= io_wdata[NCH-1:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [AW-1:0] ba, ca, bc, cc;
    logic [MW-1:0] md;
    wire hit = io_wr && data_ofs && sel_ch == g[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ba <= '0; ca <= '0; bc <= '0; cc <= '0; md <= '0;
      end else begin
        if (eng_wr[g]) begin
          ca <= eng_addr;
          cc <= eng_cnt;
        end
        if (hit && !io_addr[0]) begin
          if (ptr_hi) begin ba[15:8] <= io_wdata; ca[15:8] <= io_wdata; end
          else        begin ba[7:0]  <= io_wdata; ca[7:0]  <= io_wdata; end
        end
        if (hit && io_addr[0]) begin
          if (ptr_hi) begin bc[15:8] <= io_wdata; cc[15:8] <= io_wdata; end
          else        begin bc[7:0]  <= io_wdata; cc[7:0]  <= io_wdata; end
        end
        if (io_wr && io_addr == OFS_MODE && io_wdata[1:0] == g[1:0])
          md <= io_wdata[7:2];
      end
    end

    assign base_addr[g*AW +: AW] = ba;
    assign cur_addr[g*AW +: AW]  = ca;
    assign base_cnt[g*AW +: AW]  = bc;
    assign cur_cnt[g*AW +: AW]   = cc;
    assign ch_mode[g*MW +: MW]   = md;
  end

  assign word = io_addr[0] ? cur_cnt[sel_base +: AW] : cur_addr[sel_base +: AW];

  always_comb begin
    io_rdata = 8'h00;
    if (data_ofs)                 io_rdata = ptr_hi ? word[15:8] : word[7:0];
    else if (io_addr == OFS_CMD)  io_rdata = {sw_req | dreq_in, tc_q};
  end

  assert_exclusive_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_rd));

  assert_ptr_toggles_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> ptr_hi != $past(ptr_hi));

  assert_ptr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == OFS_PTR) |=> !ptr_hi);

  assert_mask_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == OFS_MALL) |=> ch_mask == $past(io_wdata[NCH-1:0]));

  assert_tc_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_in && !mclr) |=> (tc_q & $past(tc_in)) == $past(tc_in));

  assert_status_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_read && tc_in == '0) |=> tc_q == '0);

  assert_master_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (ch_mask == '1 && !ptr_hi && cmd == 8'h00 && sw_req == '0));

  assert_base_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && data_ofs) |=> ($stable(base_addr) && $stable(base_cnt)));
endmodule

// File: tb/tb_dmac_regfile.sv
module tb_dmac_regfile;
  logic clk = 0, rst_n = 0;
  logic io_wr = 0, io_rd = 0;
  logic [3:0] io_addr = 0;
  logic [7:0] io_wdata = 0, io_rdata;
  logic [3:0] tc_in = 0, dreq_in = 0, eng_wr = 0;
  logic [15:0] eng_addr = 0, eng_cnt = 0;
  logic [63:0] base_addr, cur_addr, base_cnt, cur_cnt;
  logic [23:0] ch_mode;
  logic [3:0] ch_mask, sw_req;
  logic [7:0] cmd;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dmac_regfile dut (.*);

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); io_wr = 1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] exp, string tag, logic [3:0] tc = 0);
    logic [7:0] got;
    @(negedge clk); io_rd = 1; io_addr = a; tc_in = tc;
    #1 got = io_rdata;
    @(negedge clk); io_rd = 0; tc_in = 0;
    chk(tag, {8'h0, got}, {8'h0, exp});
  endtask

  task automatic t_reset;
    chk("R1 mask", {12'h0, ch_mask}, 16'h000F);
    chk("R1 cmd", {8'h0, cmd}, 16'h0000);
    chk("R1 req", {12'h0, sw_req}, 16'h0000);
    chk("R1 addr", base_addr[15:0], 16'h0000);
    rd(4'h8, 8'h00, "R1 status");
    rd(4'h0, 8'h00, "R1 addr read");
    rd(4'h0, 8'h00, "R1 addr read hi");
  endtask

  task automatic t_data;
    wr(4'h2, 8'h34); wr(4'h2, 8'h12);
    wr(4'h3, 8'hCD); wr(4'h3, 8'hAB);
    chk("R2 base addr ch1", base_addr[31:16], 16'h1234);
    chk("R2 cur addr ch1", cur_addr[31:16], 16'h1234);
    chk("R2 base cnt ch1", base_cnt[31:16], 16'hABCD);
    chk("R2 cur cnt ch1", cur_cnt[31:16], 16'hABCD);
    rd(4'h2, 8'h34, "R3 read addr lo");
    rd(4'h2, 8'h12, "R3 read addr hi");
    rd(4'h3, 8'hCD, "R3 read cnt lo");
    rd(4'h3, 8'hAB, "R3 read cnt hi");
  endtask

  task automatic t_ptr;
    wr(4'h4, 8'h11); wr(4'hC, 8'h5A);
    wr(4'h4, 8'h22); wr(4'h4, 8'h33);
    chk("R4 ptr clear", base_addr[47:32], 16'h3322);
    wr(4'h0, 8'hAA); wr(4'h1, 8'hBB);
    chk("R3 shared ptr addr", base_addr[15:0], 16'h00AA);
    chk("R3 shared ptr cnt", base_cnt[15:0], 16'hBB00);
  endtask

  task automatic t_mask;
    wr(4'hE, 8'h00); chk("R6 clear all", {12'h0, ch_mask}, 16'h0000);
    wr(4'hA, 8'h06); chk("R5 set ch2", {12'h0, ch_mask}, 16'h0004);
    wr(4'hA, 8'h05); chk("R5 set ch1", {12'h0, ch_mask}, 16'h0006);
    wr(4'hA, 8'h02); chk("R5 clear ch2", {12'h0, ch_mask}, 16'h0002);
    wr(4'hF, 8'hF9); chk("R6 load all", {12'h0, ch_mask}, 16'h0009);
    wr(4'hE, 8'hFF); chk("R6 clear again", {12'h0, ch_mask}, 16'h0000);
  endtask

  task automatic t_mode;
    wr(4'hB, 8'h44); wr(4'hB, 8'h4B); wr(4'hB, 8'h55); wr(4'hB, 8'hC2);
    chk("R7 ch0 dev-to-mem", {10'h0, ch_mode[5:0]}, 16'h0011);
    chk("R7 ch1 autoinit", {10'h0, ch_mode[11:6]}, 16'h0015);
    chk("R7 ch2 cascade", {10'h0, ch_mode[17:12]}, 16'h0030);
    chk("R7 ch3 mem-to-dev", {10'h0, ch_mode[23:18]}, 16'h0012);
  endtask

  task automatic t_cmd_req;
    wr(4'h8, 8'hA5); chk("R8 cmd", {8'h0, cmd}, 16'h00A5);
    wr(4'h9, 8'h07); chk("R8 req set ch3", {12'h0, sw_req}, 16'h0008);
    rd(4'h8, 8'h80, "R8 req in status");
    wr(4'h9, 8'h03); chk("R8 req clear ch3", {12'h0, sw_req}, 16'h0000);
    wr(4'h9, 8'h07);
  endtask

  task automatic t_status;
    @(negedge clk); tc_in = 4'b0101;
    @(negedge clk); tc_in = 0;
    rd(4'h8, 8'h85, "R9 tc latched");
    dreq_in = 4'b0001;
    rd(4'h8, 8'h90, "R9 tc cleared, dreq merged", 4'b0010);
    rd(4'h8, 8'h92, "R9 same-cycle pulse kept");
    rd(4'h8, 8'h90, "R9 cleared after read");
    dreq_in = 0;
  endtask

  task automatic t_master;
    @(negedge clk); tc_in = 4'b1000;
    @(negedge clk); tc_in = 0;
    wr(4'h6, 8'h77);
    wr(4'hD, 8'h00);
    chk("R10 mask set", {12'h0, ch_mask}, 16'h000F);
    chk("R10 cmd zero", {8'h0, cmd}, 16'h0000);
    chk("R10 req zero", {12'h0, sw_req}, 16'h0000);
    chk("R10 addr kept", base_addr[31:16], 16'h1234);
    chk("R10 mode kept", {10'h0, ch_mode[5:0]}, 16'h0011);
    rd(4'h8, 8'h00, "R10 status zero");
    wr(4'h6, 8'h99); wr(4'h6, 8'h88);
    chk("R10 ptr cleared", base_addr[63:48], 16'h8899);
  endtask

  task automatic t_engine;
    @(negedge clk); eng_wr = 4'b0010; eng_addr = 16'hBEEF; eng_cnt = 16'h0010;
    @(negedge clk); eng_wr = 0;
    chk("R11 cur addr", cur_addr[31:16], 16'hBEEF);
    chk("R11 cur cnt", cur_cnt[31:16], 16'h0010);
    chk("R11 base addr kept", base_addr[31:16], 16'h1234);
    chk("R11 base cnt kept", base_cnt[31:16], 16'hABCD);
    chk("R11 other ch untouched", cur_addr[47:32], 16'h3322);
    rd(4'h2, 8'hEF, "R11 readback lo");
    rd(4'h2, 8'hBE, "R11 readback hi");
  endtask

  task automatic t_other;
    wr(4'hF, 8'h05);
    rd(4'hD, 8'h00, "R12 temp read");
    rd(4'hF, 8'h00, "R12 mask-all read");
    rd(4'hA, 8'h00, "R12 mask read");
    rd(4'hC, 8'h00, "R12 ptr-clear read");
    chk("R12 mask unchanged", {12'h0, ch_mask}, 16'h0005);
    rd(4'h3, 8'h10, "R12 ptr unchanged");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_data; t_ptr; t_mask; t_mode;
    t_cmd_req; t_status; t_master; t_engine; t_other;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule